// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block decides whether an I2C slave is being addressed. The slave may own a 10-bit address on a bus that also carries 7-bit devices. A line-level front end feeds it byte events: a start or repeated-start pulse, a received byte with a strobe, and a stop pulse. For every address byte the matcher returns an acknowledge decision. It also reports whether the slave is selected and in which direction the transfer runs.

A mode input chooses the addressing scheme. In 7-bit mode only the first byte after a start is compared. In 10-bit mode a first byte beginning with the bit pattern 11110 carries the two high address bits and the direction bit. For a write, a second byte then carries the low eight address bits. The matcher remembers a completed 10-bit write match until a stop or a failed first byte. A later repeated start with a read request and matching high bits then selects the slave for reading from that one byte, with no second byte needed.

Every decision is registered. The acknowledge and its qualifier appear one clock after the strobe of the address byte, and the selected and direction outputs change in that same cycle. Stop takes priority over start, and start takes priority over a byte strobe in the same cycle.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, ack_valid_o, ack_o, selected_o and read_o are all 0.
- R2: In 10-bit mode, a first byte of the form 11110 h1 h0 0 (bits 7..3 = 11110, bits 2..1 equal to own address bits 9..8, bit 0 = 0 for write) gets ack_valid_o=1 and ack_o=1 one cycle after the strobe, and selected_o stays 0.
- R3: The byte that follows such a first byte gets an acknowledge only if it equals own address bits 7..0. On a match, selected_o=1 and read_o=0 from the cycle of the acknowledge. On a mismatch, ack_o=0 and selected_o=0.
- R4: In 10-bit mode, a first byte with prefix 11110 whose bits 2..1 differ from the own high bits is not acknowledged, and a byte after it produces no ack_valid_o pulse.
- R5: A first byte whose bits 7..3 are 11111 is never acknowledged in either mode. In 7-bit mode, a first byte whose bits 7..4 are 1111 is never acknowledged either.
- R6: After a full 10-bit write match, a repeated start followed by 11110 h1 h0 1 with matching high bits gets an acknowledge and sets selected_o=1 and read_o=1 without a second byte.
- R7: The same read first byte, when no 10-bit write match is pending, is not acknowledged and leaves selected_o=0.
- R8: A stop clears selected_o and read_o on the next cycle and discards a pending 10-bit match.
- R9: In 7-bit mode, a first byte whose bits 7..1 equal own address bits 6..0 is acknowledged, sets selected_o=1, and sets read_o to byte bit 0. Any other first byte is not acknowledged.
- R10: A start clears selected_o on the next cycle. Bytes after the address phase produce no ack_valid_o pulse, and ack_o is 0 whenever ack_valid_o is 0.
- R11: A first byte that fails to match in 10-bit mode discards a pending 10-bit match, so a following repeated start with a read first byte is not acknowledged.
- R12: In 10-bit mode, a first byte without the 11110 prefix is not acknowledged, even if its bits 7..1 equal own address bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| byte_valid_i | input | 1 | Strobe for a received byte |
| byte_i | input | 8 | Received byte, bit 0 is the direction bit of an address byte |
| mode10_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr_i | input | 10 | Own slave address; low 7 bits used in 7-bit mode |
| ack_valid_o | output | 1 | One-cycle pulse marking an address-byte decision |
| ack_o | output | 1 | Acknowledge decision, meaningful when ack_valid_o is 1 |
| selected_o | output | 1 | Slave is addressed for the current transfer |
| read_o | output | 1 | Direction of the selected transfer, 1 for read |

## Verification
The bench goes after the remembered 10-bit match. It sends a read first byte after a completed write match, after a stop, and after a first byte aimed at another slave. A design that kept the pending match too long would select itself for a read it was never addressed for. One that dropped the match too early would refuse a legitimate repeated-start read. The bench also sends reserved 11111xx bytes with an own address that would otherwise match them, and 7-bit-looking bytes while in 10-bit mode. A design that acknowledged either would pull the bus for other devices. Finally, data bytes follow each address phase, so that a matcher which kept comparing past the address bytes would show stray acknowledge pulses.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_DATA   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pending;
        logic   selected;
        logic   read;
        logic   ack_valid;
        logic   ack;
    } match_state_t;

endpackage

// File: rtl/i2c10_first_decode.sv
module i2c10_first_decode #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              ten_prefix_o,
    output logic              hi_match_o,
    output logic              seven_match_o,
    output logic              rw_o
);
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int SEV_W  = BYTE_W - 1;
    localparam int PFX_W  = SEV_W - HI_W;
    localparam int RSV7_W = PFX_W - 1;
    localparam logic [PFX_W-1:0] TEN_PFX = {{(PFX_W-1){1'b1}}, 1'b0};

    logic [PFX_W-1:0] pfx;
    logic             rsv7;

    always_comb begin
        pfx           = byte_i[BYTE_W-1 -: PFX_W];
        rsv7          = &byte_i[BYTE_W-1 -: RSV7_W];
        ten_prefix_o  = (pfx == TEN_PFX);
        hi_match_o    = (byte_i[HI_W:1] == own_addr_i[ADDR_W-1 -: HI_W]);
        seven_match_o = !rsv7 && (byte_i[BYTE_W-1:1] == own_addr_i[SEV_W-1:0]);
        rw_o          = byte_i[0];
    end
endmodule

// File: rtl/i2c10_low_compare.sv
module i2c10_low_compare #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] low_addr_i,
    output logic              low_match_o
);
    logic [BYTE_W-1:0] bit_eq;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign bit_eq[g] = ~(byte_i[g] ^ low_addr_i[g]);
    end

    assign low_match_o = &bit_eq;
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
    import i2c10_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              mode10_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic              selected_o,
    output logic              read_o
);
    match_state_t st_d, st_q;
    logic ten_prefix, hi_match, seven_match, rw, low_match;
    logic in_first;

    i2c10_first_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_first (
        .byte_i        (byte_i),
        .own_addr_i    (own_addr_i),
        .ten_prefix_o  (ten_prefix),
        .hi_match_o    (hi_match),
        .seven_match_o (seven_match),
        .rw_o          (rw)
    );

    i2c10_low_compare #(.BYTE_W(BYTE_W)) u_low (
        .byte_i      (byte_i),
        .low_addr_i  (own_addr_i[BYTE_W-1:0]),
        .low_match_o (low_match)
    );

    assign in_first = (st_q.phase == PH_FIRST);

    always_comb begin
        st_d           = st_q;
        st_d.ack_valid = 1'b0;
        st_d.ack       = 1'b0;
        if (stop_i) begin
            st_d.phase    = PH_IDLE;
            st_d.pending  = 1'b0;
            st_d.selected = 1'b0;
            st_d.read     = 1'b0;
        end else if (start_i) begin
            st_d.phase    = PH_FIRST;
            st_d.selected = 1'b0;
            st_d.read     = 1'b0;
        end else if (byte_valid_i) begin
            unique case (st_q.phase)
                PH_FIRST: begin
                    st_d.ack_valid = 1'b1;
                    st_d.phase     = PH_DATA;
                    if (!mode10_i) begin
                        st_d.pending  = 1'b0;
                        st_d.ack      = seven_match;
                        st_d.selected = seven_match;
                        st_d.read     = seven_match && rw;
                    end else if (ten_prefix && hi_match && !rw) begin
                        st_d.ack     = 1'b1;
                        st_d.pending = 1'b0;
                        st_d.phase   = PH_SECOND;
                    end else if (ten_prefix && hi_match && rw && st_q.pending) begin
                        st_d.ack      = 1'b1;
                        st_d.selected = 1'b1;
                        st_d.read     = 1'b1;
                    end else begin
                        st_d.pending = 1'b0;
                    end
                end
                PH_SECOND: begin
                    st_d.ack_valid = 1'b1;
                    st_d.ack       = low_match;
                    st_d.selected  = low_match;
                    st_d.read      = 1'b0;
                    st_d.pending   = low_match;
                    st_d.phase     = PH_DATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pending: 1'b0, selected: 1'b0,
                      read: 1'b0, ack_valid: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_valid_o = st_q.ack_valid;
    assign ack_o       = st_q.ack;
    assign selected_o  = st_q.selected;
    assign read_o      = st_q.read;
endmodule

// File: rtl/i2c10_addr_match_sva.sv
module i2c10_addr_match_sva #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              byte_valid_i,
    input logic [BYTE_W-1:0] byte_i,
    input logic              mode10_i,
    input logic              in_first,
    input logic              ack_valid_o,
    input logic              ack_o,
    input logic              selected_o,
    input logic              read_o
);
    logic first_byte;
    assign first_byte = in_first && byte_valid_i && !start_i && !stop_i;

    p_ack_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_valid_o);

    p_start_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !selected_o);

    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!selected_o && !read_o && !ack_valid_o));

    p_reserved_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_byte && byte_i[7:3] == 5'b11111) |=> (ack_valid_o && !ack_o));

    p_write_defers_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (first_byte && mode10_i && byte_i[7:3] == 5'b11110 && !byte_i[0]) |=> !selected_o);

    p_seven_form_nack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (first_byte && mode10_i && byte_i[7:3] != 5'b11110) |=> !ack_o);

    p_select_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> (ack_valid_o && ack_o));

    p_read_implies_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        read_o |-> selected_o);
endmodule

bind i2c10_addr_match i2c10_addr_match_sva #(.BYTE_W(BYTE_W)) u_sva (.*);

// File: tb/i2c10_addr_match_test.sv
module i2c10_addr_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       mode10_i = 1'b1;
    logic [9:0] own_addr_i = 10'h2A5;
    logic       ack_valid_o, ack_o, selected_o, read_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference: 0 idle, 1 expect first, 2 expect low byte, 3 data
    int  m_step = 0;
    bit  m_pend = 0, m_sel = 0, m_read = 0, m_ackv = 0, m_ack = 0;

    always #5 clk = ~clk;

    i2c10_addr_match uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .mode10_i(mode10_i),
        .own_addr_i(own_addr_i), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .selected_o(selected_o), .read_o(read_o)
    );

    always @(posedge clk) begin
        bit hit;
        m_ackv = 0; m_ack = 0;
        if (!rst_n) begin
            m_step = 0; m_pend = 0; m_sel = 0; m_read = 0;
        end else if (stop_i) begin
            m_step = 0; m_pend = 0; m_sel = 0; m_read = 0;
        end else if (start_i) begin
            m_step = 1; m_sel = 0; m_read = 0;
        end else if (byte_valid_i && m_step == 1) begin
            m_ackv = 1; m_step = 3;
            if (!mode10_i) begin
                hit = (byte_i[7:4] != 4'hF) && (byte_i[7:1] == own_addr_i[6:0]);
                m_pend = 0; m_ack = hit; m_sel = hit; m_read = hit & byte_i[0];
            end else if (byte_i[7:3] == 5'b11110 && byte_i[2:1] == own_addr_i[9:8]) begin
                if (byte_i[0] == 0) begin
                    m_ack = 1; m_pend = 0; m_step = 2;
                end else if (m_pend) begin
                    m_ack = 1; m_sel = 1; m_read = 1;
                end else begin
                    m_pend = 0;
                end
            end else begin
                m_pend = 0;
            end
        end else if (byte_valid_i && m_step == 2) begin
            hit = (byte_i == own_addr_i[7:0]);
            m_ackv = 1; m_ack = hit; m_sel = hit; m_read = 0; m_pend = hit; m_step = 3;
        end
    end

    task automatic compare();
        checks++;
        if ({ack_valid_o, ack_o, selected_o, read_o} !== {m_ackv, m_ack, m_sel, m_read}) begin
            errors++;
            $display("FAIL %s: actual ackv/ack/sel/rd=%b%b%b%b expected=%b%b%b%b", tag,
                     ack_valid_o, ack_o, selected_o, read_o, m_ackv, m_ack, m_sel, m_read);
        end
    endtask

    // one clock: check outputs at negedge, then drive the next inputs
    task automatic step(input bit st, input bit sp, input bit bv, input logic [7:0] b);
        @(negedge clk);
        compare();
        start_i = st; stop_i = sp; byte_valid_i = bv; byte_i = b;
    endtask

    task automatic do_start();          step(1, 0, 0, 8'h00); endtask
    task automatic do_stop();           step(0, 1, 0, 8'h00); endtask
    task automatic do_byte(input logic [7:0] b); step(0, 0, 1, b); endtask
    task automatic do_idle();           step(0, 0, 0, 8'h00); endtask

    // explicit check on a single expected output tuple
    task automatic expect4(input string t, input bit av, input bit a, input bit s, input bit r);
        @(negedge clk);
        checks++;
        if ({ack_valid_o, ack_o, selected_o, read_o} !== {av, a, s, r}) begin
            errors++;
            $display("FAIL %s: actual=%b%b%b%b expected=%b%b%b%b", t,
                     ack_valid_o, ack_o, selected_o, read_o, av, a, s, r);
        end
        start_i = 0; stop_i = 0; byte_valid_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        expect4("R1 reset state", 0, 0, 0, 0);

        // R2 R3 R10 R8: full 10-bit write, data byte, stop
        tag = "R2"; do_start(); do_byte(8'hF4);
        expect4("R2 first write byte acked, not selected", 1, 1, 0, 0);
        tag = "R3"; do_byte(8'hA5);
        expect4("R3 low byte match selects write", 1, 1, 1, 0);
        tag = "R10"; do_byte(8'h12);
        expect4("R10 data byte gives no ack pulse", 0, 0, 1, 0);
        tag = "R8"; do_stop();
        expect4("R8 stop deselects", 0, 0, 0, 0);

        // R3 mismatch on low byte
        tag = "R3"; do_start(); do_byte(8'hF4); do_byte(8'hA4);
        expect4("R3 low byte mismatch nacked", 1, 0, 0, 0);
        do_stop();

        // R6 repeated start read after full match
        tag = "R6"; do_start(); do_byte(8'hF4); do_byte(8'hA5); do_start();
        expect4("R10 repeated start deselects", 0, 0, 0, 0);
        tag = "R6"; do_byte(8'hF5);
        expect4("R6 read selected from one byte", 1, 1, 1, 1);
        do_idle(); do_stop();

        // R7 read first byte after stop, no pending match
        tag = "R7"; do_start(); do_byte(8'hF5);
        expect4("R7 read without pending nacked", 1, 0, 0, 0);
        do_stop();

        // R4 wrong high bits, then a byte that would match low bits
        tag = "R4"; do_start(); do_byte(8'hF2);
        expect4("R4 high bit mismatch nacked", 1, 0, 0, 0);
        do_byte(8'hA5);
        expect4("R4 following byte ignored", 0, 0, 0, 0);
        do_stop();

        // R11 first-byte mismatch discards pending
        tag = "R11"; do_start(); do_byte(8'hF4); do_byte(8'hA5);
        do_start(); do_byte(8'h40); do_start(); do_byte(8'hF5);
        expect4("R11 pending cleared by mismatch", 1, 0, 0, 0);
        do_stop();

        // R12 7-bit form in 10-bit mode
        tag = "R12"; do_start(); do_byte(8'h4A);
        expect4("R12 seven-bit form nacked in 10-bit mode", 1, 0, 0, 0);
        do_stop();

        // R9 7-bit mode, own low7 = 0x25
        mode10_i = 1'b0;
        tag = "R9"; do_start(); do_byte(8'h4B);
        expect4("R9 seven-bit read match", 1, 1, 1, 1);
        do_stop(); do_start(); do_byte(8'h4A);
        expect4("R9 seven-bit write match", 1, 1, 1, 0);
        do_stop(); do_start(); do_byte(8'h4C);
        expect4("R9 seven-bit mismatch", 1, 0, 0, 0);
        do_stop();

        // R5 reserved prefixes with an own address that would match them
        own_addr_i = 10'h37C;
        tag = "R5"; do_start(); do_byte(8'hF8);
        expect4("R5 reserved byte nacked in 7-bit mode", 1, 0, 0, 0);
        do_stop();
        own_addr_i = 10'h378;
        do_start(); do_byte(8'hF0);
        expect4("R5 1111xxx range nacked in 7-bit mode", 1, 0, 0, 0);
        do_stop();
        mode10_i = 1'b1;
        do_start(); do_byte(8'hFE);
        expect4("R5 reserved byte nacked in 10-bit mode", 1, 0, 0, 0);
        do_stop();

        // stream of mixed traffic checked cycle by cycle
        own_addr_i = 10'h2A5; tag = "R6";
        for (int i = 0; i < 40; i++) begin
            do_start(); do_byte((i % 3 == 0) ? 8'hF4 : 8'hF5);
            do_byte((i % 5 == 0) ? 8'hA4 : 8'hA5);
            if (i % 7 == 0) do_stop();
        end
        do_stop(); do_idle(); do_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule